// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns the system clock into time quanta and walks each nominal CAN bit through four segments: a one-quantum synchronization segment, a propagation segment, then the first and second phase segments. The receive line passes through a two-flop synchronizer. The block then looks for recessive-to-dominant edges. Recessive is logic 1 and dominant is logic 0.

When the bus is idle, a falling edge restarts the bit (hard synchronization). During reception, a falling edge moves the bit boundary by the measured phase error, limited to a programmable jump width (resynchronization). The bus is sampled at the end of phase segment 1, either once or as a majority of three consecutive quanta. The result comes out with a one-clock sample strobe. A second one-clock strobe marks the start of each bit, and at that strobe the transmit bit is registered onto the transmit output.

Segment lengths are given as quantum counts, and each of them must be at least 1. The prescaler input holds the clock divide ratio minus one. The jump-width input holds the jump width minus one.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts `presc_i`+1 clock cycles. With no falling edges on the line, `sample_o` pulses for one cycle every (1+`prop_i`+`ph1_i`+`ph2_i`) quanta.
- R2: `tx_point_o` pulses when phase segment 2 ends. The next `sample_o` follows (1+`prop_i`+`ph1_i`) quanta later. The two strobes are never high in the same cycle.
- R3: A falling edge while `bus_idle_i`=1 makes the quantum in which it is detected the synchronization segment, whatever the bit position was. Detection takes two synchronizer cycles plus one quantum. `sample_o` follows `prop_i`+`ph1_i` quanta after that quantum and carries 0.
- R4: A falling edge detected in quantum k after the synchronization segment, while still before the sample point, lengthens phase segment 1 by min(k, `sjw_i`+1) quanta.
- R5: A falling edge detected in phase segment 2, with d quanta left in the segment including the current one, behaves as follows. If d ≤ `sjw_i`+1, the next bit starts in that quantum and `tx_point_o` pulses. Otherwise phase segment 2 is shortened by `sjw_i`+1 quanta.
- R6: At most one resynchronization happens between two sample points. A further edge in the same interval leaves the bit length unchanged.
- R7: While `tx_en_i`=1, falling edges cause no resynchronization.
- R8: With `triple_i`=1, the sampled bit is the majority of the line values of the last three quanta up to the sample point. With `triple_i`=0, only the last quantum's value is used. `rx_bit_o` changes only when `sample_o` pulses.
- R9: `tx_o` takes `tx_bit_i` on the cycle `tx_point_o` pulses and holds its value otherwise.
- R10: After reset, `sample_o`=0, `tx_point_o`=0, `rx_bit_o`=1 and `tx_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| tx_bit_i | input | 1 | Next bit to transmit |
| bus_idle_i | input | 1 | Bus idle; a falling edge now hard-synchronizes |
| tx_en_i | input | 1 | Node is transmitting; resynchronization suppressed |
| presc_i | input | PRESC_W | Clocks per quantum minus one |
| prop_i | input | PROP_W | Propagation segment length in quanta (≥1) |
| ph1_i | input | PH_W | Phase segment 1 length in quanta (≥1) |
| ph2_i | input | PH_W | Phase segment 2 length in quanta (≥1) |
| sjw_i | input | SJW_W | Jump width minus one |
| triple_i | input | 1 | Three-sample majority mode |
| rx_bit_o | output | 1 | Sampled bit value |
| sample_o | output | 1 | One-cycle strobe at the sample point |
| tx_point_o | output | 1 | One-cycle strobe at bit start |
| tx_o | output | 1 | Registered transmit bit |

## Verification
Every fault in the segment counter, the jump-width clipping or the resynchronization permit shows up as a wrong spacing between `sample_o` pulses. It appears in the same bit as the offending edge, or in the next one. The bench therefore times the interval between strobes against values computed from the configuration for each edge position. A corrupted sample history shows as a wrong `rx_bit_o` at the very next sample strobe. A lost transmit latch shows as a wrong `tx_o` at the next `tx_point_o`.

// File: rtl/can_btu_pkg.sv
package can_btu_pkg;
  typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_btu_prescaler.sv
module can_btu_prescaler #(
  parameter int PRESC_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] pc_q;

  // >= tolerates a ratio lowered mid-count
  assign tick_o = (pc_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else if (tick_o) pc_q <= '0;
    else pc_q <= pc_q + PRESC_W'(1);
  end
endmodule

// File: rtl/can_btu_rx_edge.sv
module can_btu_rx_edge (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  output logic       cur_o,
  output logic [1:0] hist_o,
  output logic       fall_o
);
  logic s1_q, s2_q;
  logic [1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      hist_q <= 2'b11;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      if (tick_i) hist_q <= {hist_q[0], s2_q};
    end
  end

  assign cur_o  = s2_q;
  assign hist_o = hist_q;
  // recessive in previous quantum, dominant now
  assign fall_o = hist_q[0] & ~s2_q;
endmodule

// File: rtl/can_btu_seg_ctrl.sv
module can_btu_seg_ctrl
  import can_btu_pkg::*;
#(
  parameter int PROP_W = 5,
  parameter int PH_W   = 5,
  parameter int SJW_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fall_i,
  input  logic              bus_idle_i,
  input  logic              tx_en_i,
  input  logic [PROP_W-1:0] prop_i,
  input  logic [PH_W-1:0]   ph1_i,
  input  logic [PH_W-1:0]   ph2_i,
  input  logic [SJW_W-1:0]  sjw_i,
  output logic              smp_o,
  output logic              txp_o
);
  localparam int CNT_W = ((PROP_W > PH_W) ? PROP_W : PH_W) + 1;
  localparam int E_W   = CNT_W + 1;
  localparam int X_W   = SJW_W + 1;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [X_W-1:0]   ext_q, ext_d, shr_q, shr_d;
  logic             ok_q, ok_d;

  logic [E_W-1:0] prop_w, ph1_w, ph2_w, sjw_w, cnt_w, err, rem;
  logic           hard, resync, restart;

  assign prop_w = E_W'(prop_i);
  assign ph1_w  = E_W'(ph1_i);
  assign ph2_w  = E_W'(ph2_i);
  assign sjw_w  = E_W'(sjw_i) + E_W'(1);
  assign cnt_w  = E_W'(cnt_q);
  assign err    = (seg_q == SEG_PROP) ? cnt_w + E_W'(1) : prop_w + cnt_w + E_W'(1);
  assign rem    = ph2_w - cnt_w;
  assign hard   = tick_i & fall_i & bus_idle_i;
  assign resync = tick_i & fall_i & ~bus_idle_i & ~tx_en_i & ok_q;

  always_comb begin
    seg_d   = seg_q;
    cnt_d   = cnt_q;
    ext_d   = ext_q;
    shr_d   = shr_q;
    ok_d    = ok_q;
    smp_o   = 1'b0;
    txp_o   = 1'b0;
    restart = 1'b0;
    if (resync) begin
      unique case (seg_q)
        SEG_PROP, SEG_PH1: begin
          ext_d = (err > sjw_w) ? X_W'(sjw_w) : X_W'(err);
          ok_d  = 1'b0;
        end
        SEG_PH2: begin
          ok_d = 1'b0;
          if (rem <= sjw_w) restart = 1'b1;
          else shr_d = X_W'(sjw_w);
        end
        default: ;
      endcase
    end
    if (hard) begin
      seg_d = SEG_PROP;
      cnt_d = '0;
      ext_d = '0;
      shr_d = '0;
      ok_d  = 1'b0;
    end else if (restart) begin
      // edge quantum becomes the new sync segment
      seg_d = SEG_PROP;
      cnt_d = '0;
      shr_d = '0;
      txp_o = 1'b1;
    end else if (tick_i) begin
      unique case (seg_q)
        SEG_SYNC: begin
          seg_d = SEG_PROP;
          cnt_d = '0;
        end
        SEG_PROP: begin
          if (cnt_w + E_W'(1) >= prop_w) begin
            seg_d = SEG_PH1;
            cnt_d = '0;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        SEG_PH1: begin
          if (cnt_w + E_W'(1) >= ph1_w + E_W'(ext_d)) begin
            seg_d = SEG_PH2;
            cnt_d = '0;
            ext_d = '0;
            ok_d  = 1'b1;
            smp_o = 1'b1;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
        default: begin
          if (cnt_w + E_W'(1) >= ph2_w - E_W'(shr_d)) begin
            seg_d = SEG_SYNC;
            cnt_d = '0;
            shr_d = '0;
            txp_o = 1'b1;
          end else cnt_d = cnt_q + CNT_W'(1);
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= SEG_SYNC;
      cnt_q <= '0;
      ext_q <= '0;
      shr_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      seg_q <= seg_d;
      cnt_q <= cnt_d;
      ext_q <= ext_d;
      shr_q <= shr_d;
      ok_q  <= ok_d;
    end
  end
endmodule

// File: rtl/can_btu_sampler.sv
module can_btu_sampler
  import can_btu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       smp_i,
  input  logic       txp_i,
  input  logic       triple_i,
  input  logic       cur_i,
  input  logic [1:0] hist_i,
  input  logic       tx_bit_i,
  output logic       rx_bit_o,
  output logic       sample_o,
  output logic       tx_point_o,
  output logic       tx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_bit_o   <= 1'b1;
      sample_o   <= 1'b0;
      tx_point_o <= 1'b0;
      tx_o       <= 1'b1;
    end else begin
      sample_o   <= smp_i;
      tx_point_o <= txp_i;
      if (smp_i) rx_bit_o <= triple_i ? maj3(cur_i, hist_i[0], hist_i[1]) : cur_i;
      if (txp_i) tx_o <= tx_bit_i;
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRESC_W = 10,
  parameter int PROP_W  = 5,
  parameter int PH_W    = 5,
  parameter int SJW_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  input  logic               tx_bit_i,
  input  logic               bus_idle_i,
  input  logic               tx_en_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [PROP_W-1:0]  prop_i,
  input  logic [PH_W-1:0]    ph1_i,
  input  logic [PH_W-1:0]    ph2_i,
  input  logic [SJW_W-1:0]   sjw_i,
  input  logic               triple_i,
  output logic               rx_bit_o,
  output logic               sample_o,
  output logic               tx_point_o,
  output logic               tx_o
);
  logic       tq_tick;
  logic       rx_cur, rx_fall;
  logic [1:0] rx_hist;
  logic       smp_stb, txp_stb;

  can_btu_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_i(presc_i), .tick_o(tq_tick)
  );

  can_btu_rx_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tq_tick), .rx_i(rx_i),
    .cur_o(rx_cur), .hist_o(rx_hist), .fall_o(rx_fall)
  );

  can_btu_seg_ctrl #(.PROP_W(PROP_W), .PH_W(PH_W), .SJW_W(SJW_W)) u_seg (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tq_tick), .fall_i(rx_fall),
    .bus_idle_i(bus_idle_i), .tx_en_i(tx_en_i), .prop_i(prop_i),
    .ph1_i(ph1_i), .ph2_i(ph2_i), .sjw_i(sjw_i),
    .smp_o(smp_stb), .txp_o(txp_stb)
  );

  can_btu_sampler u_smp (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_stb), .txp_i(txp_stb),
    .triple_i(triple_i), .cur_i(rx_cur), .hist_i(rx_hist), .tx_bit_i(tx_bit_i),
    .rx_bit_o(rx_bit_o), .sample_o(sample_o), .tx_point_o(tx_point_o), .tx_o(tx_o)
  );
endmodule

// File: rtl/can_btu_chk.sv
module can_btu_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic sample_o,
  input logic tx_point_o,
  input logic rx_bit_o,
  input logic tx_o
);
  // R1
  strobe_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> $past(tick_i));
  // R1
  sample_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_o && tx_point_o));
  // R8
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_o |-> $stable(rx_bit_o));
  // R9
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_point_o |-> $stable(tx_o));
endmodule

bind can_bit_timer can_btu_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tq_tick), .sample_o(sample_o),
  .tx_point_o(tx_point_o), .rx_bit_o(rx_bit_o), .tx_o(tx_o)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PROP = 2;
  localparam int PH1  = 3;
  localparam int PH2  = 3;
  localparam int SJW  = 2;
  localparam int BIT  = 1 + PROP + PH1 + PH2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_i = 1'b1, tx_bit_i = 1'b1, bus_idle_i = 1'b1, tx_en_i = 1'b0, triple_i = 1'b0;
  logic [9:0] presc_i = '0;
  logic rx_bit_o, sample_o, tx_point_o, tx_o;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  can_bit_timer u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .tx_bit_i(tx_bit_i),
    .bus_idle_i(bus_idle_i), .tx_en_i(tx_en_i), .presc_i(presc_i),
    .prop_i(5'(PROP)), .ph1_i(5'(PH1)), .ph2_i(5'(PH2)), .sjw_i(2'(SJW-1)),
    .triple_i(triple_i), .rx_bit_o(rx_bit_o), .sample_o(sample_o),
    .tx_point_o(tx_point_o), .tx_o(tx_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive rx toggles at given negedge counts, return clocks to next sample
  task automatic edge_run(input int f1, input int r1, input int f2, output int n);
    n = 0;
    forever begin
      if (n == f1 || n == f2) rx_i = 1'b0;
      if (n == r1) rx_i = 1'b1;
      @(negedge clk_i);
      n++;
      if (sample_o || n > 2000) break;
    end
  endtask

  task automatic to_sample(output int n);
    edge_run(-1, -1, -1, n);
  endtask

  task automatic to_txp(output int n);
    n = 0;
    do begin @(negedge clk_i); n++; end while (!tx_point_o && n < 2000);
  endtask

  task automatic t_reset;
    chk("R10 sample_o", sample_o, 0);
    chk("R10 tx_point_o", tx_point_o, 0);
    chk("R10 rx_bit_o", rx_bit_o, 1);
    chk("R10 tx_o", tx_o, 1);
  endtask

  task automatic t_period;
    int n;
    presc_i = 10'd1;
    to_sample(n); to_sample(n);
    to_sample(n);
    chk("R1 period presc=1", n, BIT * 2);
    to_txp(n); to_sample(n);
    chk("R2 txp to sample presc=1", n, (1 + PROP + PH1) * 2);
    presc_i = 10'd0;
    to_sample(n); to_sample(n);
    chk("R1 period presc=0", n, BIT);
  endtask

  task automatic t_txpoint;
    int n;
    tx_bit_i = 1'b0;
    to_sample(n);
    to_txp(n);
    chk("R2 sample to txp", n, PH2);
    chk("R9 tx_o latched 0", tx_o, 0);
    tx_bit_i = 1'b1;
    to_txp(n);
    chk("R9 tx_o latched 1", tx_o, 1);
  endtask

  task automatic t_hard;
    int n;
    bus_idle_i = 1'b1;
    to_sample(n);
    edge_run(0, -1, -1, n);
    chk("R3 hard sync delay", n, 3 + PROP + PH1);
    chk("R3 sampled dominant", rx_bit_o, 0);
    bus_idle_i = 1'b0;
  endtask

  task automatic t_late;
    int n;
    edge_run(4, 0, -1, n);
    chk("R4 late edge clipped", n, BIT + SJW);
    chk("R4 sampled dominant", rx_bit_o, 0);
    edge_run(2, 0, -1, n);
    chk("R4 late edge e=1", n, BIT + 1);
  endtask

  task automatic t_early;
    int n;
    rx_i = 1'b1;
    to_sample(n);
    edge_run(0, -1, -1, n);
    chk("R5 early edge restart", n, BIT - 1);
    rx_i = 1'b1;
    to_sample(n);
    edge_run(7, -1, -1, n);
    to_sample(n);
    chk("R5 early edge clipped", n, BIT - SJW);
    rx_i = 1'b1;
    to_sample(n);
    edge_run(0, 1, 3, n);
    chk("R6 second edge ignored", n, BIT - 1);
  endtask

  task automatic t_txen;
    int n;
    rx_i = 1'b1;
    tx_en_i = 1'b1;
    to_sample(n);
    edge_run(4, -1, -1, n);
    chk("R7 no resync while transmitting", n, BIT);
    rx_i = 1'b1;
  endtask

  task automatic t_triple;
    int n;
    tx_en_i = 1'b1;
    rx_i = 1'b1;
    triple_i = 1'b1;
    to_sample(n);
    edge_run(6, 7, -1, n);
    chk("R8 triple one glitch", rx_bit_o, 1);
    edge_run(5, 7, -1, n);
    chk("R8 triple two low", rx_bit_o, 0);
    triple_i = 1'b0;
    edge_run(6, 7, -1, n);
    chk("R8 single glitch", rx_bit_o, 0);
    edge_run(-1, -1, -1, n);
    chk("R8 single high", rx_bit_o, 1);
    tx_en_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_period();
    t_txpoint();
    t_hard();
    t_late();
    t_early();
    t_txen();
    t_triple();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule